// File: doc/BRIEF.md
# Sensor Sample FIFO Packer

The block takes one motion-sensor sample on each sample-rate strobe and serializes it, most significant byte first, into a byte-wide FIFO. A sample carries three accelerometer axes, one temperature word and three gyroscope axes, each 16 bits wide, on a parallel input. Two enable bits in a read/write capture register choose which groups go into the FIFO. The temperature word goes in with either group. When both groups are enabled, the order is always accelerometer, then temperature, then gyroscope.

The sample is captured on the strobe. A sequencer then pushes one byte per clock until that sample's byte sequence is complete. A strobe that arrives while a sequence is still running is dropped, and a sticky drop flag records it. The FIFO is synchronous, with first-word fall-through. It provides a pop input, a byte count and an empty flag. A byte pushed while the FIFO is full is discarded, and a sticky overflow flag is set. Both sticky flags sit in a status register and are cleared by writing 1 to them. A standby indication from the data path has no influence on buffering.

Top module: `sfp_packer`

## Requirements
- R1: The capture register at address 0x23 holds the gyro enable in bit 4 and the accel enable in bit 3. It reads back what was written in those bits. Bits 7:5 and 2:0 always read 0, and any other address reads 0x00.
- R2: With only accel enabled, a strobe pushes 8 bytes in this order: accel X hi, X lo, Y hi, Y lo, Z hi, Z lo, temp hi, temp lo. The accel input packs X in bits 47:32, Y in 31:16 and Z in 15:0; the gyro input uses the same layout.
- R3: With only gyro enabled, a strobe pushes 8 bytes in this order: temp hi, temp lo, gyro X hi, X lo, Y hi, Y lo, Z hi, Z lo.
- R4: With both enabled, a strobe pushes 14 bytes: accel X/Y/Z, then temp, then gyro X/Y/Z, each word high byte first, with temp written once.
- R5: With both enables 0, a strobe pushes nothing.
- R6: The standby_i input has no effect on capture or buffering.
- R7: The sample is captured in the cycle of the strobe. Bytes are pushed one per clock in the cycles that follow, and later changes on the sample inputs do not alter them.
- R8: A strobe that arrives while a sequence is in progress is dropped, and bit 1 of the status register at 0x24 is set. The bit stays set until 1 is written to it.
- R9: A byte pushed while the FIFO holds 64 bytes is discarded, and the count stays at 64. Bit 0 of the status register at 0x24 is then set, and it stays set until 1 is written to it.
- R10: pop_data_o shows the oldest byte. A pop removes that byte and decrements the count. A pop on an empty FIFO has no effect.
- R11: After reset the FIFO is empty, the count is 0, both enables are 0 and both sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| smp_stb_i | input | 1 | Sample-rate strobe |
| standby_i | input | 1 | Data-path standby indication, ignored |
| accel_i | input | 48 | Accel X/Y/Z words |
| temp_i | input | 16 | Temperature word |
| gyro_i | input | 48 | Gyro X/Y/Z words |
| pop_i | input | 1 | Remove head byte from the FIFO |
| pop_data_o | output | 8 | FIFO head byte |
| empty_o | output | 1 | FIFO empty |
| count_o | output | 7 | Bytes held in the FIFO |
| overflow_o | output | 1 | Sticky overflow flag |
| drop_o | output | 1 | Sticky dropped-strobe flag |

## Verification
The assertions check on every cycle that the count never exceeds the depth, that accepted pushes and pops move the count by exactly one, and that an empty-FIFO pop leaves it at zero. They also check that the sequencer's byte index stays inside its window, that a disabled strobe starts nothing, and that overflow and drop events raise their sticky flags. The byte order for each enable combination, the capture of the sample at the strobe, the ignored standby input, and write-1-to-clear can only be shown by the bench scenarios. In those scenarios the bench drains the FIFO and compares every byte and flag against values it works out from the requirements.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int WORD_W    = 16;
  localparam int SMP_WORDS = 7;
  localparam int SMP_BYTES = SMP_WORDS * 2;
  localparam int SMP_W     = SMP_WORDS * WORD_W;
  // byte index where the gyro-only window begins (temperature high byte)
  localparam int TEMP_IDX  = 6;

  // field order sets byte order: accel, temp, gyro, MSB first
  typedef struct packed {
    logic [WORD_W-1:0] ax, ay, az, t, gx, gy, gz;
  } smp_t;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign ovf_o   = push_i && full;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  // R9
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  // R10
  push_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full && !pop_i) |=> count_o == $past(count_o) + 1'b1);
  // R10
  pop_decr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> count_o == $past(count_o) - 1'b1);
  // R10
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/sfp_seq.sv
module sfp_seq
  import sfp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic       acc_en_i,
  input  logic       gyr_en_i,
  input  smp_t       smp_i,
  output logic       push_o,
  output logic [7:0] byte_o,
  output logic       drop_o
);
  localparam int IW = $clog2(SMP_BYTES);

  smp_t          smp_q;
  logic          busy_q;
  logic [IW-1:0] idx_q, last_q;
  logic          start;

  assign start  = stb_i && !busy_q && (acc_en_i || gyr_en_i);
  assign drop_o = stb_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      smp_q  <= smp_i;
      busy_q <= 1'b1;
      // accel window starts at byte 0, gyro-only window at temperature
      idx_q  <= acc_en_i ? '0 : IW'(TEMP_IDX);
      last_q <= gyr_en_i ? IW'(SMP_BYTES - 1) : IW'(TEMP_IDX + 1);
    end else if (busy_q) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + 1'b1;
    end
  end

  assign push_o = busy_q;
  assign byte_o = smp_q[(SMP_W - 8) - 8 * int'(idx_q) +: 8];

  // R7
  idx_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= last_q));
  // R5
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !busy_q && !acc_en_i && !gyr_en_i) |=> !push_o);
  // R7
  start_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !busy_q && (acc_en_i || gyr_en_i)) |=> push_o);
endmodule

// File: rtl/sfp_regs.sv
module sfp_regs #(
  parameter logic [7:0] CFG_ADDR  = 8'h23,
  parameter logic [7:0] STAT_ADDR = 8'h24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       ovf_set_i,
  input  logic       drop_set_i,
  output logic       acc_en_o,
  output logic       gyr_en_o,
  output logic       ovf_o,
  output logic       drop_o
);
  logic acc_q, gyr_q, ovf_q, drop_q;
  logic cfg_wr, stat_wr;

  assign cfg_wr  = wr_i && (addr_i == CFG_ADDR);
  assign stat_wr = wr_i && (addr_i == STAT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      gyr_q  <= 1'b0;
      ovf_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        gyr_q <= wdata_i[4];
        acc_q <= wdata_i[3];
      end
      // a new event wins over a same-cycle clear
      if (ovf_set_i)                    ovf_q  <= 1'b1;
      else if (stat_wr && wdata_i[0])   ovf_q  <= 1'b0;
      if (drop_set_i)                   drop_q <= 1'b1;
      else if (stat_wr && wdata_i[1])   drop_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR)       rdata_o = {3'b000, gyr_q, acc_q, 3'b000};
    else if (addr_i == STAT_ADDR) rdata_o = {6'b0, drop_q, ovf_q};
  end

  assign acc_en_o = acc_q;
  assign gyr_en_o = gyr_q;
  assign ovf_o    = ovf_q;
  assign drop_o   = drop_q;

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_o);
  // R8
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_set_i |=> drop_o);
  // R8
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o && !(stat_wr && wdata_i[1])) |=> drop_o);
endmodule

// File: rtl/sfp_packer.sv
module sfp_packer
  import sfp_pkg::*;
#(
  parameter int         FIFO_DEPTH = 64,
  parameter logic [7:0] CFG_ADDR   = 8'h23,
  parameter logic [7:0] STAT_ADDR  = 8'h24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_wr_i,
  input  logic [7:0]                    reg_addr_i,
  input  logic [7:0]                    reg_wdata_i,
  output logic [7:0]                    reg_rdata_o,
  input  logic                          smp_stb_i,
  input  logic                          standby_i,
  input  logic [3*WORD_W-1:0]           accel_i,
  input  logic [WORD_W-1:0]             temp_i,
  input  logic [3*WORD_W-1:0]           gyro_i,
  input  logic                          pop_i,
  output logic [7:0]                    pop_data_o,
  output logic                          empty_o,
  output logic [$clog2(FIFO_DEPTH):0]   count_o,
  output logic                          overflow_o,
  output logic                          drop_o
);
  smp_t       smp;
  logic       acc_en, gyr_en, push, ovf_ev, drop_ev;
  logic [7:0] push_byte;
  logic       unused_standby;

  // capture continues regardless of standby
  assign unused_standby = standby_i;

  assign smp = '{ax: accel_i[47:32], ay: accel_i[31:16], az: accel_i[15:0],
                 t:  temp_i,
                 gx: gyro_i[47:32],  gy: gyro_i[31:16],  gz: gyro_i[15:0]};

  sfp_regs #(.CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ovf_set_i(ovf_ev), .drop_set_i(drop_ev),
    .acc_en_o(acc_en), .gyr_en_o(gyr_en),
    .ovf_o(overflow_o), .drop_o(drop_o)
  );

  sfp_seq u_seq (
    .clk_i, .rst_ni,
    .stb_i(smp_stb_i), .acc_en_i(acc_en), .gyr_en_i(gyr_en), .smp_i(smp),
    .push_o(push), .byte_o(push_byte), .drop_o(drop_ev)
  );

  sfp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .data_i(push_byte), .pop_i(pop_i),
    .data_o(pop_data_o), .count_o(count_o), .empty_o(empty_o), .ovf_o(ovf_ev)
  );
endmodule

// File: tb/sim_sfp_packer.sv
module sim_sfp_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        stb = 1'b0, standby = 1'b0, pop = 1'b0;
  logic [47:0] accel = '0, gyro = '0;
  logic [15:0] temp = '0;
  logic [7:0]  pop_data;
  logic        empty, ovf, drop;
  logic [6:0]  count;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sfp_packer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .smp_stb_i(stb),
    .standby_i(standby), .accel_i(accel), .temp_i(temp), .gyro_i(gyro),
    .pop_i(pop), .pop_data_o(pop_data), .empty_o(empty), .count_o(count),
    .overflow_o(ovf), .drop_o(drop)
  );

  // mode[1]=gyro, mode[0]=accel, standby, accel, temp, gyro
  localparam int NV = 4;
  localparam logic [114:0] VEC [NV] = '{
    {2'b01, 1'b0, 48'h1122_3344_5566, 16'h7788, 48'h99AA_BBCC_DDEE},
    {2'b10, 1'b0, 48'h0102_0304_0506, 16'hA0B0, 48'hC1C2_C3C4_C5C6},
    {2'b11, 1'b0, 48'hF0E1_D2C3_B4A5, 16'h9687, 48'h7869_5A4B_3C2D},
    {2'b11, 1'b1, 48'h1357_9BDF_2468, 16'hACE0, 48'h0F1E_2D3C_4B5A}
  };

  task automatic chk(input logic ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic strobe(input logic [47:0] a, input logic [15:0] t, input logic [47:0] g);
    accel = a; temp = t; gyro = g; stb = 1'b1;
    @(posedge clk); @(negedge clk);
    stb = 1'b0; accel = '1; temp = 16'hDEAD; gyro = '1;   // R7: later changes ignored
  endtask

  task automatic pop_one(output logic [7:0] d);
    d = pop_data; pop = 1'b1;
    @(posedge clk); @(negedge clk);
    pop = 1'b0;
  endtask

  // expected byte k of a sample, built word by word from R2/R3/R4
  function automatic logic [7:0] exp_byte(input logic [1:0] mode, input logic [47:0] a,
                                          input logic [15:0] t, input logic [47:0] g, input int k);
    logic [15:0] words [7];
    int n = 0;
    if (mode[0]) begin words[n] = a[47:32]; words[n+1] = a[31:16]; words[n+2] = a[15:0]; n += 3; end
    words[n] = t; n++;
    if (mode[1]) begin words[n] = g[47:32]; words[n+1] = g[31:16]; words[n+2] = g[15:0]; n += 3; end
    return (k % 2 == 0) ? words[k/2][15:8] : words[k/2][7:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(empty && count == 0, "R11 empty/count", count, 0);
    chk(!ovf && !drop, "R11 flags", {ovf, drop}, 0);
    rd_reg(8'h23, d);
    chk(d == 8'h00, "R11 cfg", d, 0);

    // R1 readback and reserved bits
    wr_reg(8'h23, 8'hFF);
    rd_reg(8'h23, d);
    chk(d == 8'h18, "R1 reserved read 0", d, 8'h18);
    wr_reg(8'h23, 8'h08);
    rd_reg(8'h23, d);
    chk(d == 8'h08, "R1 accel bit", d, 8'h08);
    rd_reg(8'h40, d);
    chk(d == 8'h00, "R1 other address", d, 0);

    // vector table: R2, R3, R4, R6, R7, R10
    for (int v = 0; v < NV; v++) begin
      logic [1:0] mode;
      logic [47:0] a, g;
      logic [15:0] t;
      int len;
      string tag;
      mode = VEC[v][114:113]; standby = VEC[v][112];
      a = VEC[v][111:64]; t = VEC[v][63:48]; g = VEC[v][47:0];
      len = (mode == 2'b11) ? 14 : 8;
      tag = (mode == 2'b01) ? "R2" : (mode == 2'b10) ? "R3" : (standby ? "R6" : "R4");
      wr_reg(8'h23, {3'b000, mode[1], mode[0], 3'b000});
      strobe(a, t, g);
      repeat (len + 1) @(negedge clk);
      chk(count == 7'(len), $sformatf("%s count", tag), count, len);
      for (int k = 0; k < len; k++) begin
        logic [7:0] e;
        e = exp_byte(mode, a, t, g, k);
        pop_one(d);
        chk(d == e, $sformatf("%s R7 byte %0d", tag, k), d, e);
      end
      chk(empty, $sformatf("%s R10 drained", tag), count, 0);
      standby = 1'b0;
    end

    // R5 both enables off
    wr_reg(8'h23, 8'h00);
    strobe(48'h1, 16'h2, 48'h3);
    repeat (16) @(negedge clk);
    chk(empty && count == 0, "R5 nothing pushed", count, 0);

    // R8 strobe during sequence
    wr_reg(8'h23, 8'h18);
    strobe(48'h1, 16'h2, 48'h3);
    strobe(48'h4, 16'h5, 48'h6);
    repeat (16) @(negedge clk);
    chk(count == 14, "R8 second strobe dropped", count, 14);
    chk(drop == 1'b1, "R8 drop flag", drop, 1);
    rd_reg(8'h24, d);
    chk(d[1] == 1'b1, "R8 status bit1", d, 8'h02);
    repeat (5) @(negedge clk);
    chk(drop == 1'b1, "R8 sticky", drop, 1);
    wr_reg(8'h24, 8'h02);
    chk(drop == 1'b0, "R8 w1c", drop, 0);

    // R9 overflow: 14 held + 4*14 pushed = 70 offered
    for (int s = 0; s < 4; s++) begin
      strobe(48'hABCD, 16'h1234, 48'h5678);
      repeat (16) @(negedge clk);
    end
    chk(count == 64, "R9 count saturates", count, 64);
    chk(ovf == 1'b1, "R9 overflow flag", ovf, 1);
    wr_reg(8'h24, 8'h00);
    chk(ovf == 1'b1, "R9 write 0 keeps flag", ovf, 1);
    wr_reg(8'h24, 8'h01);
    chk(ovf == 1'b0, "R9 w1c", ovf, 0);

    // R10 drain, then pop on empty
    for (int k = 0; k < 64; k++) pop_one(d);
    chk(empty && count == 0, "R10 drained", count, 0);
    pop_one(d);
    chk(empty && count == 0, "R10 pop on empty", count, 0);
    wr_reg(8'h23, 8'h08);
    strobe(48'h0102_0304_0506, 16'h0708, 48'h0);
    repeat (10) @(negedge clk);
    chk(count == 8 && pop_data == 8'h01, "R10 head after empty pop", pop_data, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule